// File: doc/BRIEF.md
# Dual-Organisation ROM Read Port

This block is the read side of a 4 Mbit read-only store. The store can be read either as 256K words of 16 bits or as 512K bytes. The array contents come from a computed pattern. Part of the address space carries that pattern, and the rest reads as erased, with every bit at one. A host drives an 18-bit word address, two active-low strobes (chip select and output enable), an organisation select and an identifier-mode flag. One extra input, the shared pin, carries data bit 15 in word organisation; in byte organisation it is the byte-lane address bit. Each of the 16 data outputs has its own enable, so the tri-state behaviour can be observed in simulation.

Access delays are modelled as cycle counts. All inputs are sampled on the rising clock edge, and the outputs are registered, so a change sampled at an edge shows on the outputs right after that edge. The chip-select timer needs `ACC_CYCLES` consecutive samples with select low and an unchanged access key. The output-enable timer needs `OE_CYCLES` consecutive samples with enable low. Until both timers are satisfied, the driven outputs read zero and the invalid flag is set. In identifier mode the array is bypassed and a fixed maker code or part code is returned.

Top module: `rom_rdport`

## Requirements
- R1: While reset is held, all output enables are 0, the data outputs and the invalid flag are 0, and the standby output is 1.
- R2: After an edge that samples chip select high, all output enables are 0 and standby is 1, whatever output enable does; standby follows the sampled chip select.
- R3: After an edge that samples chip select low and output enable high, all output enables are 0 and standby is 0.
- R4: With the organisation select at 1 (word) and both strobes low, all 16 output enables are 1 and a valid read shows the full addressed word on bits 15..0.
- R5: With the organisation select at 0 (byte), only enables 7..0 are 1. A valid read puts the low byte of the addressed word on bits 7..0 when the shared pin is 0, and the high byte when it is 1.
- R6: In identifier mode a valid read returns 0x20 on bits 7..0 when address bit 0 is 0, and 0xB2 when it is 1. Bits 15..8 read 0, and the other address bits have no effect.
- R7: A word at address a below 0x20000 holds ((a mod 65536) XOR 0xA5C3) + (a div 65536) mod 65536. Every word at 0x20000 or above reads 0xFFFF (erased).
- R8: A read becomes valid on the `ACC_CYCLES`-th consecutive edge that samples chip select low with an unchanged key. Before that, while both strobes are low, the enables are on, the data read 0 and the invalid flag is 1.
- R9: A read also needs `OE_CYCLES` consecutive edges that sample output enable low; until then the invalid flag stays 1.
- R10: A change in the access key restarts the chip-select count at one. The key is made of the address, the organisation, the identifier flag, and the shared pin in byte organisation.
- R11: Outputs go to high impedance right after the first edge that samples either strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 18 | Word address |
| lsb_pin_i | input | 1 | Shared pin: byte-lane select in byte organisation |
| cs_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| wide_i | input | 1 | Organisation select: 1 word, 0 byte |
| ident_i | input | 1 | Identifier-mode flag |
| dout_o | output | 16 | Data outputs |
| dout_en_o | output | 16 | Per-bit output enables |
| dout_x_o | output | 1 | Data driven but not yet valid |
| sleep_o | output | 1 | Standby indication |

## Verification
The assertions check on every cycle the properties that follow from the strobes and the organisation. These are: standby and high impedance after chip select is sampled high, output disable, the enable mask in word and byte organisations, zero upper bits in identifier mode, zero data whenever the invalid flag is set, and the restart after a key change or an output-enable fall. The exact data values, such as the stored pattern, the erased region boundary and the lane selection, can only be shown by the bench. The same holds for the exact edge on which a read turns valid, which the bench's cycle-accurate model confirms.

// File: rtl/rom_rdport_pkg.sv
package rom_rdport_pkg;

  localparam int RP_ADDR_W = 18;
  localparam int RP_WORD_W = 16;
  localparam int RP_LANE_W = 8;
  localparam int RP_LANES  = RP_WORD_W / RP_LANE_W;

  typedef enum logic {
    ORG_BYTE = 1'b0,
    ORG_WORD = 1'b1
  } org_e;

  // Everything whose change restarts the access timer
  typedef struct packed {
    logic [RP_ADDR_W-1:0] addr;
    org_e                 org;
    logic                 ident;
    logic                 lane_hi;
  } acc_key_t;

  // Stored pattern: low address bits scrambled by a seed, high bits added
  function automatic logic [RP_WORD_W-1:0] fold_pattern(
    input logic [RP_ADDR_W-1:0] a,
    input logic [RP_WORD_W-1:0] seed
  );
    logic [RP_WORD_W-1:0] lo;
    logic [RP_WORD_W-1:0] hi;
    lo = a[RP_WORD_W-1:0] ^ seed;
    hi = RP_WORD_W'(a >> RP_WORD_W);
    return lo + hi;
  endfunction

  function automatic logic [RP_LANE_W-1:0] pick_lane(
    input logic [RP_WORD_W-1:0] w,
    input logic                 hi
  );
    return hi ? w[RP_WORD_W-1 -: RP_LANE_W] : w[RP_LANE_W-1:0];
  endfunction

endpackage

// File: rtl/rom_pattern_src.sv
module rom_pattern_src
  import rom_rdport_pkg::*;
#(
  parameter logic [RP_ADDR_W-1:0] PROG_LIMIT = 18'h20000,
  parameter logic [RP_WORD_W-1:0] SEED       = 16'hA5C3
) (
  input  logic [RP_ADDR_W-1:0] waddr_i,
  output logic [RP_WORD_W-1:0] word_o
);

  logic erased_w;

  assign erased_w = (waddr_i >= PROG_LIMIT);

  always_comb begin
    if (erased_w) word_o = '1;
    else          word_o = fold_pattern(waddr_i, SEED);
  end

endmodule

// File: rtl/rom_access_timer.sv
module rom_access_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic restart_i,
  output logic hit_o
);

  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (!active_i)                        cnt_d = '0;
    else if (restart_i || cnt_q == '0)    cnt_d = ONE;
    else if (cnt_q >= TOP)                cnt_d = cnt_q;
    else                                  cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit_o = active_i && (cnt_d >= TOP);

endmodule

// File: rtl/rom_lane_mux.sv
module rom_lane_mux
  import rom_rdport_pkg::*;
#(
  parameter logic [RP_LANE_W-1:0] MFR_CODE = 8'h20,
  parameter logic [RP_LANE_W-1:0] DEV_CODE = 8'hB2
) (
  input  logic [RP_WORD_W-1:0] word_i,
  input  org_e                 org_i,
  input  logic                 lane_hi_i,
  input  logic                 ident_i,
  input  logic                 id_sel_i,
  output logic [RP_WORD_W-1:0] data_o,
  output logic [RP_WORD_W-1:0] mask_o
);

  logic [RP_LANE_W-1:0] code_w;

  assign code_w = id_sel_i ? DEV_CODE : MFR_CODE;

  // Lane 0 always drives; upper lanes only in word organisation
  for (genvar g = 0; g < RP_LANES; g++) begin : g_lane
    if (g == 0) begin : g_base
      assign mask_o[g*RP_LANE_W +: RP_LANE_W] = '1;
    end else begin : g_upper
      assign mask_o[g*RP_LANE_W +: RP_LANE_W] = {RP_LANE_W{org_i == ORG_WORD}};
    end
  end

  always_comb begin
    data_o = '0;
    if (ident_i)               data_o[RP_LANE_W-1:0] = code_w;
    else if (org_i == ORG_WORD) data_o = word_i;
    else                       data_o[RP_LANE_W-1:0] = pick_lane(word_i, lane_hi_i);
  end

endmodule

// File: rtl/rom_out_stage.sv
module rom_out_stage
  import rom_rdport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 drive_i,
  input  logic                 valid_i,
  input  logic                 standby_i,
  input  logic [RP_WORD_W-1:0] data_i,
  input  logic [RP_WORD_W-1:0] mask_i,
  output logic [RP_WORD_W-1:0] dout_o,
  output logic [RP_WORD_W-1:0] dout_en_o,
  output logic                 dout_x_o,
  output logic                 sleep_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_o    <= '0;
      dout_en_o <= '0;
      dout_x_o  <= 1'b0;
      sleep_o   <= 1'b1;
    end else begin
      dout_o    <= valid_i ? data_i : '0;
      dout_en_o <= drive_i ? mask_i : '0;
      dout_x_o  <= drive_i && !valid_i;
      sleep_o   <= standby_i;
    end
  end

endmodule

// File: rtl/rom_rdport.sv
module rom_rdport
  import rom_rdport_pkg::*;
#(
  parameter int unsigned          ACC_CYCLES = 4,
  parameter int unsigned          OE_CYCLES  = 2,
  parameter logic [RP_ADDR_W-1:0] PROG_LIMIT = 18'h20000,
  parameter logic [RP_WORD_W-1:0] SEED       = 16'hA5C3,
  parameter logic [RP_LANE_W-1:0] MFR_CODE   = 8'h20,
  parameter logic [RP_LANE_W-1:0] DEV_CODE   = 8'hB2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RP_ADDR_W-1:0] addr_i,
  input  logic                 lsb_pin_i,
  input  logic                 cs_n_i,
  input  logic                 oe_n_i,
  input  logic                 wide_i,
  input  logic                 ident_i,
  output logic [RP_WORD_W-1:0] dout_o,
  output logic [RP_WORD_W-1:0] dout_en_o,
  output logic                 dout_x_o,
  output logic                 sleep_o
);

  org_e                 org_w;
  acc_key_t             key_now_w;
  acc_key_t             key_q;
  logic                 key_chg_w;
  logic                 ce_hit_w;
  logic                 oe_hit_w;
  logic                 drive_w;
  logic                 valid_w;
  logic [RP_WORD_W-1:0] word_w;
  logic [RP_WORD_W-1:0] data_w;
  logic [RP_WORD_W-1:0] mask_w;

  assign org_w = wide_i ? ORG_WORD : ORG_BYTE;

  always_comb begin
    key_now_w.addr    = addr_i;
    key_now_w.org     = org_w;
    key_now_w.ident   = ident_i;
    key_now_w.lane_hi = (org_w == ORG_BYTE) ? lsb_pin_i : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key_now_w;
  end

  assign key_chg_w = (key_now_w != key_q);

  rom_access_timer #(.LIMIT(ACC_CYCLES)) u_ce_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (!cs_n_i),
    .restart_i (key_chg_w),
    .hit_o     (ce_hit_w)
  );

  rom_access_timer #(.LIMIT(OE_CYCLES)) u_oe_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (!oe_n_i),
    .restart_i (1'b0),
    .hit_o     (oe_hit_w)
  );

  rom_pattern_src #(.PROG_LIMIT(PROG_LIMIT), .SEED(SEED)) u_array (
    .waddr_i (addr_i),
    .word_o  (word_w)
  );

  rom_lane_mux #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_mux (
    .word_i    (word_w),
    .org_i     (org_w),
    .lane_hi_i (key_now_w.lane_hi),
    .ident_i   (ident_i),
    .id_sel_i  (addr_i[0]),
    .data_o    (data_w),
    .mask_o    (mask_w)
  );

  assign drive_w = !cs_n_i && !oe_n_i;
  assign valid_w = drive_w && ce_hit_w && oe_hit_w;

  rom_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_i   (drive_w),
    .valid_i   (valid_w),
    .standby_i (cs_n_i),
    .data_i    (data_w),
    .mask_i    (mask_w),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o),
    .dout_x_o  (dout_x_o),
    .sleep_o   (sleep_o)
  );

endmodule

// File: rtl/rom_rdport_chk.sv
module rom_rdport_chk #(
  parameter int unsigned ACC_CYCLES = 4,
  parameter int unsigned OE_CYCLES  = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic [17:0] addr_i,
  input logic        cs_n_i,
  input logic        oe_n_i,
  input logic        wide_i,
  input logic        ident_i,
  input logic [15:0] dout_o,
  input logic [15:0] dout_en_o,
  input logic        dout_x_o,
  input logic        sleep_o,
  input logic        key_chg
);

  logic live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> (dout_en_o == '0 && sleep_o)); // R2

  AST_OUTPUT_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && oe_n_i) |=> (dout_en_o == '0 && !sleep_o)); // R3

  AST_WORD_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && !oe_n_i && wide_i) |=> (&dout_en_o)); // R4

  AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_i |=> (dout_en_o[15:8] == '0)); // R5

  AST_IDENT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ident_i |=> (dout_o[15:8] == '0)); // R6

  AST_INVALID_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dout_x_o |-> (dout_en_o[0] && dout_o == '0)); // R8

  AST_OE_FALL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && OE_CYCLES > 1 && $fell(oe_n_i) && !cs_n_i) |=> dout_x_o); // R9

  AST_KEY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ACC_CYCLES > 1 && key_chg && !cs_n_i && !oe_n_i) |=> dout_x_o); // R10

  AST_DEASSERT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && ($rose(oe_n_i) || $rose(cs_n_i))) |=> (dout_en_o == '0 && !dout_x_o)); // R11

  AST_ADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(addr_i)); // R7

endmodule

bind rom_rdport rom_rdport_chk #(
  .ACC_CYCLES (ACC_CYCLES),
  .OE_CYCLES  (OE_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_i    (addr_i),
  .cs_n_i    (cs_n_i),
  .oe_n_i    (oe_n_i),
  .wide_i    (wide_i),
  .ident_i   (ident_i),
  .dout_o    (dout_o),
  .dout_en_o (dout_en_o),
  .dout_x_o  (dout_x_o),
  .sleep_o   (sleep_o),
  .key_chg   (key_chg_w)
);

// File: tb/sim_rom_rdport.sv
`timescale 1ns/100ps
module sim_rom_rdport;

  localparam int ACC = 4;
  localparam int OEC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic        pin = 1'b0;
  logic        cs_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        wide = 1'b1;
  logic        ident = 1'b0;
  logic [15:0] dout;
  logic [15:0] dout_en;
  logic        dout_x;
  logic        sleep;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rom_rdport #(.ACC_CYCLES(ACC), .OE_CYCLES(OEC)) u0 (
    .clk (clk), .rst_n (rst_n), .addr_i (addr), .lsb_pin_i (pin),
    .cs_n_i (cs_n), .oe_n_i (oe_n), .wide_i (wide), .ident_i (ident),
    .dout_o (dout), .dout_en_o (dout_en), .dout_x_o (dout_x), .sleep_o (sleep)
  );

  // Stored content as stated in R7, computed in integer arithmetic
  function automatic logic [15:0] ref_word(input int a);
    int v;
    if (a >= 'h20000) return 16'hFFFF;
    v = ((a % 65536) ^ 'hA5C3) + (a / 65536);
    return 16'(v % 65536);
  endfunction

  function automatic logic [15:0] ref_data();
    logic [15:0] w;
    if (ident) return addr[0] ? 16'h00B2 : 16'h0020;
    w = ref_word(int'(addr));
    if (wide) return w;
    return pin ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  // Behavioural reference: run lengths of the strobes, previous key
  int          ce_run, oe_run;
  logic [21:0] prev_key;
  logic [15:0] exp_dq, exp_en;
  logic        exp_x, exp_sb;

  always @(posedge clk or negedge rst_n) begin
    logic [21:0] k;
    bit drive, valid;
    if (!rst_n) begin
      ce_run = 0; oe_run = 0; prev_key = '0;
      exp_dq = '0; exp_en = '0; exp_x = 0; exp_sb = 1;
    end else begin
      k = {addr, wide, ident, wide ? 1'b0 : pin};
      if (cs_n) ce_run = 0;
      else if (k != prev_key || ce_run == 0) ce_run = 1;
      else if (ce_run < 1000) ce_run++;
      prev_key = k;
      if (oe_n) oe_run = 0;
      else if (oe_run < 1000) oe_run++;
      drive  = !cs_n && !oe_n;
      valid  = drive && ce_run >= ACC && oe_run >= OEC;
      exp_sb = cs_n;
      exp_en = drive ? (wide ? 16'hFFFF : 16'h00FF) : 16'h0000;
      exp_x  = drive && !valid;
      exp_dq = valid ? ref_data() : 16'h0000;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (dout_en !== exp_en) begin
        failures++;
        $display("FAIL R11 enables actual=%h expected=%h t=%0t", dout_en, exp_en, $time);
      end else if (dout !== exp_dq) begin
        failures++;
        $display("FAIL R7 data actual=%h expected=%h t=%0t", dout, exp_dq, $time);
      end else if (dout_x !== exp_x) begin
        failures++;
        $display("FAIL R8 invalid flag actual=%b expected=%b t=%0t", dout_x, exp_x, $time);
      end else if (sleep !== exp_sb) begin
        failures++;
        $display("FAIL R2 standby actual=%b expected=%b t=%0t", sleep, exp_sb, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk("R1 reset enables", 32'(dout_en), 32'h0);
    chk("R1 reset data", 32'(dout), 32'h0);
    chk("R1 reset flag", 32'(dout_x), 32'h0);
    chk("R1 reset standby", 32'(sleep), 32'h1);
    rst_n = 1'b1;
    tick(2);

    // Word read, timing from both strobes together
    addr = 18'h00123; wide = 1; cs_n = 0; oe_n = 0;
    tick(1);
    chk("R8 early invalid", 32'(dout_x), 32'h1);
    chk("R4 word enables", 32'(dout_en), 32'hFFFF);
    tick(2);
    chk("R8 still invalid", 32'(dout_x), 32'h1);
    tick(1);
    chk("R8 valid at count", 32'(dout_x), 32'h0);
    chk("R4 R7 word data", 32'(dout), 32'(ref_word('h123)));

    // Address change restarts the access count
    addr = 18'h1ABCD;
    tick(1);
    chk("R10 restart flag", 32'(dout_x), 32'h1);
    tick(3);
    chk("R7 high-bank data", 32'(dout), 32'(ref_word('h1ABCD)));

    // Output enable alone, select held low
    oe_n = 1;
    tick(1);
    chk("R11 R3 disable enables", 32'(dout_en), 32'h0);
    chk("R3 not standby", 32'(sleep), 32'h0);
    oe_n = 0;
    tick(1);
    chk("R9 enable wait", 32'(dout_x), 32'h1);
    tick(1);
    chk("R9 valid after enable count", 32'(dout), 32'(ref_word('h1ABCD)));

    // Byte organisation, both lanes
    wide = 0; pin = 0; addr = 18'h00456;
    tick(4);
    chk("R5 byte enables", 32'(dout_en), 32'h00FF);
    chk("R5 low lane", 32'(dout), 32'(ref_word('h456) & 16'h00FF));
    pin = 1;
    tick(1);
    chk("R10 lane restart", 32'(dout_x), 32'h1);
    tick(3);
    chk("R5 high lane", 32'(dout), 32'(ref_word('h456) >> 8));

    // Erased region and its boundary
    wide = 1; addr = 18'h3FFFF;
    tick(4);
    chk("R7 erased top", 32'(dout), 32'hFFFF);
    addr = 18'h20000;
    tick(4);
    chk("R7 erased boundary", 32'(dout), 32'hFFFF);
    addr = 18'h1FFFF;
    tick(4);
    chk("R7 last programmed", 32'(dout), 32'(ref_word('h1FFFF)));

    // Identifier mode
    ident = 1; addr = 18'h0;
    tick(4);
    chk("R6 maker code", 32'(dout), 32'h0020);
    addr = 18'h1;
    tick(4);
    chk("R6 part code", 32'(dout), 32'h00B2);
    addr = 18'h2A5;
    tick(4);
    chk("R6 other bits ignored", 32'(dout), 32'h00B2);

    // Standby regardless of output enable
    ident = 0; cs_n = 1;
    tick(1);
    chk("R2 standby enables", 32'(dout_en), 32'h0);
    chk("R2 standby flag", 32'(sleep), 32'h1);
    cs_n = 0;
    tick(1);
    chk("R2 wake invalid", 32'(dout_x), 32'h1);
    tick(3);
    chk("R2 wake data", 32'(dout), 32'(ref_word('h2A5)));

    cs_n = 1; oe_n = 1;
    tick(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule